// File: doc/BRIEF.md
# Reconfigurable Two-Stage Product-Term Fabric

This block is a programmable combinational array that evaluates any Boolean function written as a sum of products. The first stage is a grid of product rows crossing the data inputs; each crossing holds a cell with a 2-bit mode, and a row is true only when every cell on it lets its signal through. The second stage is a grid of the same kind. Its control lines are the first-stage row results and its columns are the outputs. Each output is an AND of complemented row results, so the user programs the complement of the target function as rows and obtains the function itself.

The mode image is written bit by bit through a serial configuration port while the array is idle. The same hardware becomes a priority encoder, a multiplexer, a demultiplexer or any other function of its inputs, with no change other than a new image. Results are registered once at the output, and they carry a valid flag that drops while a load is running.

Top module: `pt_fabric`

## Requirements
- R1: A cell mode is 2 bits: 2'b00 always passes, 2'b01 passes when its control line is 1, 2'b10 passes when its control line is 0, 2'b11 never passes.
- R2: First-stage row r is 1 exactly when every one of its N_IN cells passes, where cell (r,i) uses data input i as its control and its mode sits at image bits [2*(r*N_IN+i)+1 : 2*(r*N_IN+i)].
- R3: Output o is 1 exactly when every one of its N_ROWS second-stage cells passes, where cell (o,r) uses row r as its control and its mode sits at image bits starting at 2*N_ROWS*N_IN + 2*(o*N_ROWS+r).
- R4: On every clock edge with cfg_en high, the image shifts up by one bit and cfg_data enters bit 0, so after a full load the first bit sent occupies the top bit of the image.
- R5: While cfg_en is low the image does not change, whatever cfg_data and the data inputs do.
- R6: out_valid is 0 in the cycle after any edge that samples cfg_en high, and 1 after an edge that samples it low.
- R7: cfg_done is 1 only while cfg_en is low and the most recent load session shifted at least as many bits as the image holds; a new session clears it, and a short session leaves it at 0.
- R8: Reset fills the image with 2'b11, so that out_vec is 0 for every input, cfg_done is 0 and out_valid is 0.
- R9: out_vec presents the function of the in_vec value sampled at the previous clock edge (one register of latency).
- R10: With the priority-encoder image, out_vec[2:0] is the index of the highest-numbered 1 among in_vec[7:0], and 0 when all of them are 0.
- R11: With the multiplexer image, out_vec[0] equals in_vec[s], where s = in_vec[10:8].
- R12: With the demultiplexer image, out_vec[j] equals in_vec[0] when j = in_vec[3:1] and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Shift enable for the mode image |
| cfg_data | input | 1 | Serial image bit |
| cfg_done | output | 1 | Image fully loaded and the port is idle |
| in_vec | input | N_IN | Data inputs (first-stage control lines) |
| out_vec | output | N_OUT | Registered function outputs |
| out_valid | output | 1 | Outputs reflect a stable image |

## Verification
Every function result is due one clock edge after the data inputs change, because the only register between in_vec and out_vec is the output stage. The bench therefore drives each vector on a falling edge and samples on the next falling edge. A configuration bit takes effect at the edge that samples it. cfg_done responds at once to cfg_en falling and is read just after that falling edge. out_valid is read one edge after cfg_en is sampled high or low, in the same half-cycle windows as the data results.

// File: rtl/pt_pkg.sv
package pt_pkg;

    typedef enum logic [1:0] {
        MODE_ANY = 2'b00,
        MODE_HI  = 2'b01,
        MODE_LO  = 2'b10,
        MODE_OFF = 2'b11
    } cell_mode_e;

    function automatic logic cell_pass(input logic [1:0] mode, input logic ctl);
        case (cell_mode_e'(mode))
            MODE_ANY: cell_pass = 1'b1;
            MODE_HI:  cell_pass = ctl;
            MODE_LO:  cell_pass = ~ctl;
            default:  cell_pass = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pt_cfg_chain.sv
module pt_cfg_chain #(
    parameter int CHAIN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_data,
    output logic [CHAIN-1:0] img_o,
    output logic             cfg_done
);
    localparam int CW = $clog2(CHAIN + 1);

    typedef struct packed {
        logic [CHAIN-1:0] img;
        logic [CW-1:0]    cnt;
        logic             en_prev;
    } chain_t;

    chain_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.en_prev = cfg_en;
        if (cfg_en) begin
            s_d.img = {s_q.img[CHAIN-2:0], cfg_data};
            if (!s_q.en_prev)
                s_d.cnt = CW'(1);
            else if (s_q.cnt != CW'(CHAIN))
                s_d.cnt = s_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.img     <= '1;
            s_q.cnt     <= '0;
            s_q.en_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign img_o    = s_q.img;
    assign cfg_done = (s_q.cnt == CW'(CHAIN)) && !cfg_en;

    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(img_o));
    p_shift_in_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (img_o[0] == $past(cfg_data)));
    p_new_session_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !s_q.en_prev) |=> (s_q.cnt == CW'(1)));

endmodule

// File: rtl/pt_row.sv
module pt_row
    import pt_pkg::*;
#(
    parameter int N_CTL = 8
) (
    input  logic [N_CTL-1:0]   ctl,
    input  logic [2*N_CTL-1:0] modes,
    output logic               pass_o
);
    logic [N_CTL-1:0] cell_ok;
    logic [N_CTL-1:0] cell_off;
    logic [N_CTL-1:0] cell_any;

    for (genvar i = 0; i < N_CTL; i++) begin : g_cell
        assign cell_ok[i]  = cell_pass(modes[2*i +: 2], ctl[i]);
        assign cell_off[i] = (modes[2*i +: 2] == MODE_OFF);
        assign cell_any[i] = (modes[2*i +: 2] == MODE_ANY);
    end

    assign pass_o = &cell_ok;

    always_comb begin
        p_off_blocks_r1: assert (!((|cell_off) && pass_o));
        p_all_any_r2:    assert (!((&cell_any) && !pass_o));
    end

endmodule

// File: rtl/pt_fabric.sv
module pt_fabric
    import pt_pkg::*;
#(
    parameter int N_IN    = 11,
    parameter int N_ROWS  = 16,
    parameter int N_OUT   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_data,
    output logic             cfg_done,
    input  logic [N_IN-1:0]  in_vec,
    output logic [N_OUT-1:0] out_vec,
    output logic             out_valid
);
    localparam int S1_BITS = 2 * N_ROWS * N_IN;
    localparam int S2_BITS = 2 * N_OUT * N_ROWS;
    localparam int CHAIN   = S1_BITS + S2_BITS;

    logic [CHAIN-1:0]  img;
    logic [N_ROWS-1:0] row_hit;
    logic [N_OUT-1:0]  comb_out;

    pt_cfg_chain #(.CHAIN(CHAIN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_data (cfg_data),
        .img_o    (img),
        .cfg_done (cfg_done)
    );

    for (genvar r = 0; r < N_ROWS; r++) begin : g_stage1
        pt_row #(.N_CTL(N_IN)) u_row (
            .ctl    (in_vec),
            .modes  (img[2*r*N_IN +: 2*N_IN]),
            .pass_o (row_hit[r])
        );
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_stage2
        pt_row #(.N_CTL(N_ROWS)) u_col (
            .ctl    (row_hit),
            .modes  (img[S1_BITS + 2*o*N_ROWS +: 2*N_ROWS]),
            .pass_o (comb_out[o])
        );
    end

    if (REG_OUT) begin : g_oreg
        typedef struct packed {
            logic [N_OUT-1:0] data;
            logic             valid;
        } oreg_t;

        oreg_t o_d, o_q;

        always_comb begin
            o_d       = o_q;
            o_d.data  = comb_out;
            o_d.valid = !cfg_en;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) o_q <= '0;
            else        o_q <= o_d;
        end

        assign out_vec   = o_q.data;
        assign out_valid = o_q.valid;

        p_valid_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_en |=> !out_valid);
        p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
            !cfg_en |=> (out_vec == $past(comb_out)));
    end else begin : g_comb
        assign out_vec   = comb_out;
        assign out_valid = !cfg_en;
    end

    p_dark_rows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (row_hit == '0 && img[CHAIN-1 -: 2] == 2'b11) |-> !comb_out[N_OUT-1]);

endmodule

// File: tb/pt_fabric_tb.sv
module pt_fabric_tb;
    localparam int N_IN    = 11;
    localparam int N_ROWS  = 16;
    localparam int N_OUT   = 8;
    localparam int S1_BITS = 2 * N_ROWS * N_IN;
    localparam int CHAIN   = S1_BITS + 2 * N_OUT * N_ROWS;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_en = 1'b0;
    logic             cfg_data = 1'b0;
    logic             cfg_done;
    logic [N_IN-1:0]  in_vec = '0;
    logic [N_OUT-1:0] out_vec;
    logic             out_valid;

    int n_tests = 0;
    int n_fail  = 0;
    logic [CHAIN-1:0] img;

    always #2.5 clk = ~clk;

    pt_fabric #(.N_IN(N_IN), .N_ROWS(N_ROWS), .N_OUT(N_OUT), .REG_OUT(1'b1)) u_dut (
        .clk, .rst_n, .cfg_en, .cfg_data, .cfg_done, .in_vec, .out_vec, .out_valid
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic mpass(input logic [1:0] m, input logic c);
        case (m)
            2'b00:   return 1'b1;
            2'b01:   return c;
            2'b10:   return ~c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [N_OUT-1:0] model(input logic [CHAIN-1:0] im,
                                               input logic [N_IN-1:0] x);
        logic [N_ROWS-1:0] rows;
        logic [N_OUT-1:0]  y;
        for (int r = 0; r < N_ROWS; r++) begin
            rows[r] = 1'b1;
            for (int i = 0; i < N_IN; i++)
                rows[r] &= mpass(im[2*(r*N_IN+i) +: 2], x[i]);
        end
        for (int o = 0; o < N_OUT; o++) begin
            y[o] = 1'b1;
            for (int r = 0; r < N_ROWS; r++)
                y[o] &= mpass(im[S1_BITS + 2*(o*N_ROWS+r) +: 2], rows[r]);
        end
        return y;
    endfunction

    task automatic s1(input int r, input int i, input logic [1:0] m);
        img[2*(r*N_IN+i) +: 2] = m;
    endtask

    task automatic s2(input int o, input int r, input logic [1:0] m);
        img[S1_BITS + 2*(o*N_ROWS+r) +: 2] = m;
    endtask

    task automatic clear_img();
        img = '0;
        for (int r = 0; r < N_ROWS; r++)
            for (int i = 0; i < N_IN; i++) s1(r, i, 2'b11);
    endtask

    task automatic load_img();
        for (int k = CHAIN - 1; k >= 0; k--) begin
            @(negedge clk);
            if (k == CHAIN - 20) check("R6 valid low while loading", 32'(out_valid), 32'd0);
            cfg_en   = 1'b1;
            cfg_data = img[k];
        end
        @(negedge clk);
        cfg_en = 1'b0;
        #1;
        check("R7 done after full load", 32'(cfg_done), 32'd1);
    endtask

    task automatic apply(input logic [N_IN-1:0] x, output logic [N_OUT-1:0] y);
        in_vec = x;
        cfg_data = 1'($urandom);
        @(negedge clk);
        y = out_vec;
    endtask

    function automatic logic [2:0] prio(input logic [7:0] x);
        logic [2:0] idx = 3'd0;
        for (int k = 0; k < 8; k++) if (x[k]) idx = 3'(k);
        return idx;
    endfunction

    initial begin
        logic [N_OUT-1:0] y;
        logic [N_IN-1:0]  x;
        int bad;
        void'($urandom(32'h1badcafe));
        repeat (3) @(negedge clk);
        #1;
        check("R8 reset out_vec", 32'(out_vec), 32'd0);
        check("R8 reset cfg_done", 32'(cfg_done), 32'd0);
        check("R8 reset out_valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6 valid after idle edge", 32'(out_valid), 32'd1);
        bad = 0;
        for (int t = 0; t < 40; t++) begin
            apply(N_IN'($urandom), y);
            if (y != '0) bad++;
        end
        check("R8 blocked image gives zeros", 32'(bad), 32'd0);

        // R10 priority encoder
        clear_img();
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < 8; j++) s1(k, j, (j == k) ? 2'b01 : (j > k) ? 2'b10 : 2'b00);
            for (int j = 8; j < N_IN; j++) s1(k, j, 2'b00);
            for (int b = 0; b < 3; b++) s2(b, k, k[b] ? 2'b00 : 2'b10);
        end
        for (int j = 0; j < N_IN; j++) s1(8, j, (j < 8) ? 2'b10 : 2'b00);
        for (int b = 0; b < 3; b++) s2(b, 8, 2'b10);
        load_img();
        bad = 0;
        for (int v = 0; v < 256; v++) begin
            x = {3'($urandom), 8'(v)};
            apply(x, y);
            if (y[2:0] != prio(8'(v))) begin
                bad++;
                if (bad == 1) check("R10 encoder index", 32'(y[2:0]), 32'(prio(8'(v))));
            end
        end
        check("R10 encoder sweep mismatches", 32'(bad), 32'd0);
        check("R10 all-zero input gives 0", 32'(prio(8'd0)), 32'd0);
        apply(11'h080, y);
        check("R9 encoder top bit", 32'(y[2:0]), 32'd7);

        // R11 multiplexer
        clear_img();
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < N_IN; j++) s1(k, j, 2'b00);
            s1(k, k, 2'b10);
            for (int b = 0; b < 3; b++) s1(k, 8 + b, k[b] ? 2'b01 : 2'b10);
            s2(0, k, 2'b10);
        end
        load_img();
        bad = 0;
        for (int v = 0; v < 2048; v++) begin
            x = 11'(v);
            apply(x, y);
            if (y[0] != x[x[10:8]]) bad++;
        end
        check("R11 mux sweep mismatches", 32'(bad), 32'd0);

        // R12 demultiplexer
        clear_img();
        for (int k = 0; k < 8; k++) begin
            for (int j = 0; j < N_IN; j++) s1(k, j, 2'b00);
            for (int b = 0; b < 3; b++) s1(k, 1 + b, k[b] ? 2'b01 : 2'b10);
            for (int j = 0; j < N_OUT; j++) if (j != k) s2(j, k, 2'b10);
        end
        for (int j = 0; j < N_IN; j++) s1(8, j, (j == 0) ? 2'b10 : 2'b00);
        for (int j = 0; j < N_OUT; j++) s2(j, 8, 2'b10);
        load_img();
        bad = 0;
        for (int v = 0; v < 256; v++) begin
            x = {7'($urandom), 4'(v)};
            apply(x, y);
            if (y != (N_OUT'(x[0]) << x[3:1])) bad++;
        end
        check("R12 demux mismatches", 32'(bad), 32'd0);

        // R7 short session leaves done low
        @(negedge clk);
        cfg_en = 1'b1;
        repeat (5) @(negedge clk);
        cfg_en = 1'b0;
        #1;
        check("R7 short session", 32'(cfg_done), 32'd0);

        // R1 R2 R3 R4 R5 random images against the bench model
        for (int c = 0; c < 12; c++) begin
            for (int k = 0; k < CHAIN / 2; k++) begin
                int p = int'($urandom % 10);
                img[2*k +: 2] = (p < 6) ? 2'b00 : (p < 8) ? 2'b01 : (p < 9) ? 2'b10 : 2'b11;
            end
            load_img();
            bad = 0;
            for (int t = 0; t < 60; t++) begin
                x = N_IN'($urandom);
                if (t < 30) for (int i = 0; i < N_IN; i++) if (($urandom % 3) == 0) x[i] = 1'b0;
                apply(x, y);
                if (y != model(img, x)) bad++;
            end
            check("R1 R2 R3 R4 R5 random image", 32'(bad), 32'd0);
        end
        check("R6 valid after load", 32'(out_valid), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule